// File: doc/BRIEF.md
# DMA Descriptor Condition Evaluator

This unit makes the three end-of-command decisions for a descriptor-driven DMA channel. It decides whether to hold the channel in a wait state, whether to request an interrupt, and whether to take the branch to the descriptor's alternate address. The sequencer that fetches descriptors and moves pointers sits outside this block. It presents the command word, the device status byte and three select registers, one each for wait, interrupt and branch, and it pulses a strobe.

Each decision is built from a masked compare of the low four device-status bits against the compare value in that decision's select register. A 2-bit code from the command word then qualifies the result: never, when the compare matches, when it does not match, or always. The decisions are registered on the clock edge at which the strobe is high. They hold until the next strobe.

The wait decision takes priority. A command that waits neither interrupts nor branches at that point.

Top module: `dma_cond_eval`

## Requirements
- R1: After reset, `irq_req`, `br_taken`, `wait_hold` and `dec_valid` are all 0.
- R2: The command word carries three 2-bit codes: interrupt in bits [5:4], branch in bits [3:2] and wait in bits [1:0]. Code 00 gives a decision of 0, 01 gives the compare result, 10 gives its inverse, and 11 gives a decision of 1. All other command bits have no effect.
- R3: Each select register holds a 4-bit mask in bits [19:16] and a 4-bit compare value in bits [3:0]. The compare is true when `(dev_status[3:0] & mask) == (value & mask)`. Bits outside these two fields have no effect.
- R4: Bits [7:4] of `dev_status` have no effect on any decision.
- R5: A mask of zero makes the compare true regardless of status and value.
- R6: The interrupt decision uses only `irq_sel`, the branch decision only `br_sel`, and the wait decision only `wait_sel`.
- R7: The wait decision is evaluated first. When it is 1, `irq_req` and `br_taken` are 0 for that evaluation, whatever their codes.
- R8: The decisions and a 1-cycle `dec_valid` pulse appear on the clock edge at which `eval_valid` is sampled high.
- R9: While `eval_valid` is low, the decision outputs keep their last values even if other inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_valid | input | 1 | Evaluate strobe |
| cmd_word | input | 16 | Descriptor command word |
| dev_status | input | 8 | Device status byte |
| irq_sel | input | 32 | Interrupt select register |
| br_sel | input | 32 | Branch select register |
| wait_sel | input | 32 | Wait select register |
| irq_req | output | 1 | Interrupt decision |
| br_taken | output | 1 | Branch decision |
| wait_hold | output | 1 | Wait decision |
| dec_valid | output | 1 | Decision update pulse |

## Verification
The bench uses the default parameters: a 16-bit command word, an 8-bit status byte, 32-bit select registers, a 4-bit compare and the mask at bit 16. At these sizes every code of all three fields can be reached against mask patterns that are full, partial and zero.

The bench fills the unused select bits, the unused command bits and the upper status nibble with non-zero values, so any leak from them would show in a decision. Directed steps then cover the reset state, the one-cycle valid pulse, and holding the outputs with no strobe while the inputs change.

// File: rtl/dma_cond_eval.sv
module dma_cond_eval #(
  parameter int CMD_W    = 16,
  parameter int STAT_W   = 8,
  parameter int SEL_W    = 32,
  parameter int CMP_W    = 4,
  parameter int MASK_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [STAT_W-1:0] dev_status,
  input  logic [SEL_W-1:0]  irq_sel,
  input  logic [SEL_W-1:0]  br_sel,
  input  logic [SEL_W-1:0]  wait_sel,
  output logic              irq_req,
  output logic              br_taken,
  output logic              wait_hold,
  output logic              dec_valid
);

  localparam int WT_LSB  = 0;
  localparam int BR_LSB  = 2;
  localparam int INT_LSB = 4;

  function automatic logic cmp_hit(input logic [STAT_W-1:0] st,
                                   input logic [SEL_W-1:0]  sel);
    logic [CMP_W-1:0] msk;
    logic [CMP_W-1:0] val;
    msk = sel[MASK_LSB +: CMP_W];
    val = sel[CMP_W-1:0];
    return ((st[CMP_W-1:0] ^ val) & msk) == '0;
  endfunction

  function automatic logic qualify(input logic [1:0] code, input logic hit);
    case (code)
      2'b00:   return 1'b0;
      2'b01:   return hit;
      2'b10:   return !hit;
      default: return 1'b1;
    endcase
  endfunction

  logic hit_w, hit_i, hit_b;
  logic go_w, go_i, go_b;

  assign hit_w = cmp_hit(dev_status, wait_sel);
  assign hit_i = cmp_hit(dev_status, irq_sel);
  assign hit_b = cmp_hit(dev_status, br_sel);

  assign go_w = qualify(cmd_word[WT_LSB +: 2], hit_w);
  assign go_i = !go_w && qualify(cmd_word[INT_LSB +: 2], hit_i);
  assign go_b = !go_w && qualify(cmd_word[BR_LSB +: 2], hit_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req   <= 1'b0;
      br_taken  <= 1'b0;
      wait_hold <= 1'b0;
      dec_valid <= 1'b0;
    end else begin
      dec_valid <= eval_valid;
      if (eval_valid) begin
        wait_hold <= go_w;
        irq_req   <= go_i;
        br_taken  <= go_b;
      end
    end
  end

  // R8
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_valid |=> dec_valid);

  // R8
  no_strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_valid |=> !dec_valid);

  // R9
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_valid |=> $stable({irq_req, br_taken, wait_hold}));

  // R7
  wait_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_hold |-> (!irq_req && !br_taken));

  // R2
  wait_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_valid && cmd_word[WT_LSB +: 2] == 2'b11) |=> wait_hold);

  // R2
  irq_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_valid && cmd_word[INT_LSB +: 2] == 2'b00) |=> !irq_req);

endmodule

// File: tb/dma_cond_eval_bench.sv
module dma_cond_eval_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [7:0]  dev_status = '0;
  logic [31:0] irq_sel = '0;
  logic [31:0] br_sel = '0;
  logic [31:0] wait_sel = '0;
  logic        irq_req, br_taken, wait_hold, dec_valid;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  dma_cond_eval u_dma_cond_eval (
    .clk(clk), .rst_n(rst_n), .eval_valid(eval_valid),
    .cmd_word(cmd_word), .dev_status(dev_status),
    .irq_sel(irq_sel), .br_sel(br_sel), .wait_sel(wait_sel),
    .irq_req(irq_req), .br_taken(br_taken), .wait_hold(wait_hold),
    .dec_valid(dec_valid)
  );

  // ctl[40:35] {int,br,wait}, st[34:27], im, iv, bm, bv, wm, wv, exp{w,i,b}[2:0]
  localparam int NV = 16;
  localparam logic [40:0] VEC [NV] = '{
    {6'b00_00_00, 8'h00, 4'h0,4'h0, 4'h0,4'h0, 4'h0,4'h0, 3'b000}, // R2 never
    {6'b11_11_00, 8'h00, 4'h0,4'h0, 4'h0,4'h0, 4'h0,4'h0, 3'b011}, // R2 always
    {6'b00_00_11, 8'h00, 4'h0,4'h0, 4'h0,4'h0, 4'h0,4'h0, 3'b100}, // R2 wait always
    {6'b11_11_11, 8'h00, 4'h0,4'h0, 4'h0,4'h0, 4'h0,4'h0, 3'b100}, // R7
    {6'b01_00_00, 8'h05, 4'hF,4'h5, 4'h0,4'h0, 4'h0,4'h0, 3'b010}, // R3 match
    {6'b01_00_00, 8'h05, 4'hF,4'h4, 4'h0,4'h0, 4'h0,4'h0, 3'b000}, // R3 miss
    {6'b10_00_00, 8'h05, 4'hF,4'h4, 4'h0,4'h0, 4'h0,4'h0, 3'b010}, // R2 if-clear
    {6'b00_01_00, 8'h0A, 4'h0,4'h0, 4'h2,4'h2, 4'h0,4'h0, 3'b001}, // R3 partial mask
    {6'b00_10_00, 8'h0A, 4'h0,4'h0, 4'h2,4'h2, 4'h0,4'h0, 3'b000}, // R2 br if-clear
    {6'b00_00_01, 8'h03, 4'h0,4'h0, 4'h0,4'h0, 4'h1,4'h1, 3'b100}, // R2 wait if-set
    {6'b00_00_10, 8'h03, 4'h0,4'h0, 4'h0,4'h0, 4'h1,4'h1, 3'b000}, // R2 wait if-clear
    {6'b01_01_00, 8'h06, 4'h0,4'hF, 4'h0,4'h9, 4'h0,4'h0, 3'b011}, // R5 zero mask
    {6'b10_10_00, 8'h06, 4'h0,4'hF, 4'h0,4'h9, 4'h0,4'h0, 3'b000}, // R5 zero mask inv
    {6'b01_00_00, 8'hF0, 4'hF,4'h0, 4'h0,4'h0, 4'h0,4'h0, 3'b010}, // R4 upper nibble
    {6'b11_11_01, 8'h00, 4'h0,4'h0, 4'h0,4'h0, 4'h1,4'h1, 3'b011}, // R7 wait false
    {6'b01_01_01, 8'h01, 4'h1,4'h1, 4'h1,4'h0, 4'h1,4'h0, 3'b010}  // R6 own selects
  };

  function automatic logic [31:0] mk_sel(input logic [3:0] m, input logic [3:0] v);
    return {12'hABC, m, 12'h5A5, v};
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic strobe();
    eval_valid = 1'b1;
    @(negedge clk);
    eval_valid = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1", {dec_valid, wait_hold, irq_req, br_taken}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {dec_valid, wait_hold, irq_req, br_taken}, 4'b0000);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      cmd_word   = {10'h2D6, VEC[k][40:35]};
      dev_status = VEC[k][34:27];
      irq_sel    = mk_sel(VEC[k][26:23], VEC[k][22:19]);
      br_sel     = mk_sel(VEC[k][18:15], VEC[k][14:11]);
      wait_sel   = mk_sel(VEC[k][10:7],  VEC[k][6:3]);
      strobe();
      // R2 R3 R8 vector result with valid pulse
      check($sformatf("R2/R3 vec%0d", k), {dec_valid, wait_hold, irq_req, br_taken},
            {1'b1, VEC[k][2:0]});
    end

    // R8 pulse lasts one cycle
    @(negedge clk);
    check("R8 pulse end", {3'b000, dec_valid}, 4'b0000);

    // R9 outputs hold with inputs changing and no strobe (last vec gave 010)
    cmd_word = 16'h003F;
    dev_status = 8'hFF;
    irq_sel = '0; br_sel = '0; wait_sel = '0;
    repeat (3) @(negedge clk);
    check("R9 hold", {dec_valid, wait_hold, irq_req, br_taken}, 4'b0010);

    // R6 irq select ignored by branch: br if-set with br mask missing, irq matching
    cmd_word = 16'h0014;
    dev_status = 8'h03;
    irq_sel = mk_sel(4'hF, 4'h3);
    br_sel  = mk_sel(4'hF, 4'hC);
    wait_sel = mk_sel(4'hF, 4'h0);
    strobe();
    check("R6 split", {dec_valid, wait_hold, irq_req, br_taken}, 4'b1010);

    // R1 reset clears held decisions
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reassert", {dec_valid, wait_hold, irq_req, br_taken}, 4'b0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule